// File: doc/BRIEF.md
# Embedded-Sync Video Byte Decoder

This block takes an 8-bit video byte stream that carries its own timing and has no separate sync wires. Each video line is framed by four-byte timing words: the three-byte preamble `FF 00 00`, then a status byte. In the status byte, bit 4 is set for an end-of-active-video word and clear for a start-of-active-video word. Bit 5 is set while the stream is inside vertical blanking. The decoder finds these words, rebuilds line and frame timing from them, and passes on only the active picture bytes. Each output byte carries start-of-line and start-of-frame marks.

Horizontal blanking bytes, bytes of blanking lines and the timing words themselves never reach the pixel output. Every timing word produces a one-cycle event that reports its end and vertical-blanking flags. A frame start is recognised only after at least one timing word with the blanking flag set has been seen. A receiver downstream of a camera port uses the pixel output to write lines into memory and uses the event output to count lines or frames.

The preamble can only be recognised once its fourth byte has arrived. Every accepted byte therefore waits in a three-slot history before it leaves the block. The three slots are discarded when a timing word completes.

Top module: `emb_sync_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `px_valid`, `px_sol`, `px_sof`, `delim_evt`, `delim_end` and `delim_vblank` are all low.
- R2: The sequence FF, 00, 00 followed by any status byte, accepted on four beats, raises `delim_evt` for exactly one cycle, on the cycle after the status byte is accepted. In that cycle `delim_end` equals status bit 4 and `delim_vblank` equals status bit 5.
- R3: Bytes after a start word whose bit 5 is clear, and up to the next timing word, appear on `px_data` with `px_valid` high, in arrival order. A byte is presented in the cycle after the third accepted byte that follows it.
- R4: None of the four bytes of a timing word ever appears with `px_valid` high, and `px_valid` is low in every cycle in which `delim_evt` is high.
- R5: Bytes that arrive outside an active line are never presented. This covers bytes after an end word, bytes before the first start word, and bytes of lines whose start word has bit 5 set.
- R6: `px_sol` is high together with `px_valid` on the first byte presented after each start word with bit 5 clear, and low on every other byte.
- R7: `px_sof` is high on the first byte of the first active line whose start word follows one or more timing words with bit 5 set. It is low on every other byte, including all bytes before any such blanking word since reset.
- R8: An end word that arrives with no active line open still raises its event, and leaves the output invalid until the next start word with bit 5 clear.
- R9: A cycle with `in_valid` low accepts nothing, and the cycle after it shows `px_valid` low. Idle cycles placed between any two bytes, including inside a timing word, do not change the decoded result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_byte` on this edge |
| in_byte | input | 8 | Incoming stream byte |
| px_valid | output | 1 | An active picture byte is on `px_data` this cycle |
| px_data | output | 8 | Active picture byte |
| px_sol | output | 1 | First byte of a line |
| px_sof | output | 1 | First byte of a frame |
| delim_evt | output | 1 | One-cycle pulse per decoded timing word |
| delim_end | output | 1 | Event is an end-of-active-video word |
| delim_vblank | output | 1 | Event's word carries the vertical-blanking flag |

## Verification
The bench checks the last three bytes of a line, which leave the block only while the end word's preamble is arriving. A design that decided too late or too early would either drop these bytes or pass the preamble bytes out as picture data. The bench also sends an end word with no open line, lines of zero length, and an opening frame that has no blanking before it. A design that got these wrong would emit a partial line, leave a stale line-start mark, or flag a frame start that was never established. Idle beats fall inside timing words and inside lines, so a decoder that matched on clock cycles instead of accepted bytes would lose or invent words.

// File: rtl/emb_sync_pkg.sv
package emb_sync_pkg;

    localparam int unsigned BYTE_W       = 8;
    localparam int unsigned PREAMBLE_LEN = 3;
    localparam int unsigned FLAG_END_BIT = 4;
    localparam int unsigned FLAG_VBL_BIT = 5;

    localparam logic [BYTE_W-1:0] PRE_LEAD = 8'hFF;
    localparam logic [BYTE_W-1:0] PRE_FILL = 8'h00;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              act;
        logic              sol;
        logic              sof;
    } slot_t;

endpackage

// File: rtl/esd_code_detect.sv
module esd_code_detect
    import emb_sync_pkg::*;
#(
    parameter int unsigned DEPTH = PREAMBLE_LEN
) (
    input  logic [DEPTH-1:0][BYTE_W-1:0] hist,
    input  logic                         cur_valid,
    input  logic [BYTE_W-1:0]            cur_byte,
    output logic                         hit,
    output logic                         is_end,
    output logic                         vblank
);

    logic [DEPTH-1:0] match;

    // hist[DEPTH-1] is the oldest byte and must be the lead byte
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        if (i == DEPTH - 1) begin : g_lead
            assign match[i] = (hist[i] == PRE_LEAD);
        end else begin : g_fill
            assign match[i] = (hist[i] == PRE_FILL);
        end
    end

    assign hit    = cur_valid && (&match);
    assign is_end = cur_byte[FLAG_END_BIT];
    assign vblank = cur_byte[FLAG_VBL_BIT];

endmodule

// File: rtl/esd_timing_fsm.sv
module esd_timing_fsm
    import emb_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              hit,
    input  logic              is_end,
    input  logic              vblank,
    output slot_t             new_slot,
    output logic              evt,
    output logic              evt_end,
    output logic              evt_vbl
);

    typedef struct packed {
        logic active;
        logic vb_seen;
        logic sol_pend;
        logic sof_pend;
        logic evt;
        logic evt_end;
        logic evt_vbl;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.evt     = 1'b0;
        st_d.evt_end = 1'b0;
        st_d.evt_vbl = 1'b0;
        new_slot.data = in_byte;
        new_slot.act  = 1'b0;
        new_slot.sol  = 1'b0;
        new_slot.sof  = 1'b0;
        if (acc) begin
            if (hit) begin
                st_d.evt     = 1'b1;
                st_d.evt_end = is_end;
                st_d.evt_vbl = vblank;
                if (!is_end && !vblank) begin
                    st_d.active   = 1'b1;
                    st_d.sol_pend = 1'b1;
                    st_d.sof_pend = st_q.vb_seen;
                    st_d.vb_seen  = 1'b0;
                end else begin
                    st_d.active   = 1'b0;
                    st_d.sol_pend = 1'b0;
                    st_d.sof_pend = 1'b0;
                    if (vblank) begin
                        st_d.vb_seen = 1'b1;
                    end
                end
            end else begin
                new_slot.act = st_q.active;
                new_slot.sol = st_q.active && st_q.sol_pend;
                new_slot.sof = st_q.active && st_q.sof_pend;
                if (st_q.active) begin
                    st_d.sol_pend = 1'b0;
                    st_d.sof_pend = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt     = st_q.evt;
    assign evt_end = st_q.evt_end;
    assign evt_vbl = st_q.evt_vbl;

    AST_SOF_AFTER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.sof_pend) |-> $past(st_q.vb_seen)); // R7

    AST_PEND_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sol_pend |-> st_q.active); // R6

endmodule

// File: rtl/esd_delay_line.sv
module esd_delay_line
    import emb_sync_pkg::*;
#(
    parameter int unsigned DEPTH = PREAMBLE_LEN
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         kill,
    input  slot_t                        in_slot,
    output logic [DEPTH-1:0][BYTE_W-1:0] hist,
    output logic                         o_valid,
    output logic [BYTE_W-1:0]            o_data,
    output logic                         o_sol,
    output logic                         o_sof
);

    typedef struct packed {
        slot_t [DEPTH-1:0] slots;
        logic              o_valid;
        logic [BYTE_W-1:0] o_data;
        logic              o_sol;
        logic              o_sof;
    } dl_t;

    dl_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.o_valid = 1'b0;
        st_d.o_sol   = 1'b0;
        st_d.o_sof   = 1'b0;
        if (push) begin
            st_d.o_valid = st_q.slots[DEPTH-1].act && !kill;
            st_d.o_sol   = st_q.slots[DEPTH-1].sol && !kill;
            st_d.o_sof   = st_q.slots[DEPTH-1].sof && !kill;
            st_d.o_data  = st_q.slots[DEPTH-1].data;
            for (int i = DEPTH - 1; i > 0; i--) begin
                st_d.slots[i] = st_q.slots[i-1];
                if (kill) begin
                    st_d.slots[i].act = 1'b0;
                    st_d.slots[i].sol = 1'b0;
                    st_d.slots[i].sof = 1'b0;
                end
            end
            st_d.slots[0] = in_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_hist
        assign hist[i] = st_q.slots[i].data;
    end

    assign o_valid = st_q.o_valid;
    assign o_data  = st_q.o_data;
    assign o_sol   = st_q.o_sol;
    assign o_sof   = st_q.o_sof;

    AST_SOL_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.o_sol |-> st_q.o_valid); // R6

    AST_SOF_HAS_SOL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.o_sof |-> st_q.o_sol); // R7

endmodule

// File: rtl/emb_sync_decoder.sv
module emb_sync_decoder
    import emb_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              px_valid,
    output logic [BYTE_W-1:0] px_data,
    output logic              px_sol,
    output logic              px_sof,
    output logic              delim_evt,
    output logic              delim_end,
    output logic              delim_vblank
);

    localparam int unsigned DEPTH = PREAMBLE_LEN;

    logic [DEPTH-1:0][BYTE_W-1:0] hist;
    logic                         code_hit;
    logic                         code_end;
    logic                         code_vbl;
    slot_t                        fresh_slot;

    esd_code_detect #(.DEPTH(DEPTH)) u_detect (
        .hist      (hist),
        .cur_valid (in_valid),
        .cur_byte  (in_byte),
        .hit       (code_hit),
        .is_end    (code_end),
        .vblank    (code_vbl)
    );

    esd_timing_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (in_valid),
        .in_byte  (in_byte),
        .hit      (code_hit),
        .is_end   (code_end),
        .vblank   (code_vbl),
        .new_slot (fresh_slot),
        .evt      (delim_evt),
        .evt_end  (delim_end),
        .evt_vbl  (delim_vblank)
    );

    esd_delay_line #(.DEPTH(DEPTH)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (in_valid),
        .kill    (code_hit),
        .in_slot (fresh_slot),
        .hist    (hist),
        .o_valid (px_valid),
        .o_data  (px_data),
        .o_sol   (px_sol),
        .o_sof   (px_sof)
    );

    AST_DELIM_NOT_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        delim_evt |-> !px_valid); // R4

    AST_IDLE_NO_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> !px_valid); // R9

    AST_FLAGS_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (delim_end || delim_vblank) |-> delim_evt); // R2

endmodule

// File: tb/emb_sync_decoder_test.sv
module emb_sync_decoder_test;

    localparam time CLK_P = 8ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       px_valid, px_sol, px_sof;
    logic [7:0] px_data;
    logic       delim_evt, delim_end, delim_vblank;

    emb_sync_decoder uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .px_valid     (px_valid),
        .px_data      (px_data),
        .px_sol       (px_sol),
        .px_sof       (px_sof),
        .delim_evt    (delim_evt),
        .delim_end    (delim_end),
        .delim_vblank (delim_vblank)
    );

    always #(CLK_P / 2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int gap_ctr = 0;

    logic [7:0] exp_data [1024];
    logic       exp_sol  [1024];
    logic       exp_sof  [1024];
    int         exp_n = 0;
    int         got_n = 0;
    logic       exp_ev_end [256];
    logic       exp_ev_vb  [256];
    int         ev_n = 0;
    int         ev_got = 0;
    string      stray_req = "R5";
    logic       acc_at_edge = 1'b0;

    always @(posedge clk) acc_at_edge <= in_valid;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
        end
    endtask

    // output monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (px_valid) begin
                chk(acc_at_edge, "R9", 0, 1);
                if (got_n >= exp_n) begin
                    chk(1'b0, stray_req, px_data, 0);
                end else begin
                    chk(px_data == exp_data[got_n], "R3", px_data, exp_data[got_n]);
                    chk(px_sol == exp_sol[got_n], "R6", px_sol, exp_sol[got_n]);
                    chk(px_sof == exp_sof[got_n], "R7", px_sof, exp_sof[got_n]);
                end
                got_n++;
            end
            if (delim_evt) begin
                chk(!px_valid, "R4", px_valid, 0);
                if (ev_got < ev_n) begin
                    chk(delim_end == exp_ev_end[ev_got], "R2", delim_end, exp_ev_end[ev_got]);
                    chk(delim_vblank == exp_ev_vb[ev_got], "R2", delim_vblank, exp_ev_vb[ev_got]);
                end else begin
                    chk(1'b0, "R2", ev_got, ev_n);
                end
                ev_got++;
            end
        end
    end

    task automatic send_raw(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        gap_ctr++;
        if (gap_ctr % 5 == 3) begin
            @(posedge clk);
            #1;
        end
        send_raw(b);
    endtask

    task automatic expect_px(input logic [7:0] b, input logic s, input logic f);
        exp_data[exp_n] = b;
        exp_sol[exp_n]  = s;
        exp_sof[exp_n]  = f;
        exp_n++;
    endtask

    // status: bit4 end flag, bit5 vertical blanking flag
    task automatic send_code(input logic e, input logic v);
        logic [7:0] st;
        if (!e && !v)     st = 8'h80;
        else if (!e && v) st = 8'hAB;
        else if (e && !v) st = 8'h9D;
        else              st = 8'hB6;
        exp_ev_end[ev_n] = e;
        exp_ev_vb[ev_n]  = v;
        ev_n++;
        send_byte(8'hFF);
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte(st);
    endtask

    task automatic hblank();
        send_byte(8'h80);
        send_byte(8'h10);
        send_byte(8'h80);
    endtask

    function automatic logic [7:0] pix(input int seed, input int k);
        return 8'(1 + ((seed * 13 + k * 29) % 254));
    endfunction

    task automatic send_line(input int len, input int seed, input logic sof_exp);
        send_code(1'b0, 1'b0);
        for (int k = 0; k < len; k++) begin
            expect_px(pix(seed, k), k == 0, (k == 0) && sof_exp);
            send_byte(pix(seed, k));
        end
        send_code(1'b1, 1'b0);
        hblank();
    endtask

    task automatic send_vblank_line(input int len);
        send_code(1'b0, 1'b1);
        for (int k = 0; k < len; k++) send_byte((k % 2) ? 8'h80 : 8'h10);
        send_code(1'b1, 1'b1);
        hblank();
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", got_n, exp_n);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet during reset
        chk({px_valid, px_sol, px_sof, delim_evt, delim_end, delim_vblank} == 6'b0, "R1",
            {px_valid, px_sol, px_sof, delim_evt, delim_end, delim_vblank}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({px_valid, px_sol, px_sof, delim_evt, delim_end, delim_vblank} == 6'b0, "R1",
            {px_valid, px_sol, px_sof, delim_evt, delim_end, delim_vblank}, 0);
        @(posedge clk);
        #1;

        // R8: stray end word with no open line, surrounding junk must not appear
        stray_req = "R8";
        send_byte(8'h41);
        send_byte(8'h42);
        send_code(1'b1, 1'b0);
        send_byte(8'h43);
        send_byte(8'h44);
        send_byte(8'h45);
        send_byte(8'h46);
        chk(got_n == 0 && !px_valid, "R8", got_n, 0);
        stray_req = "R5";

        // R3: latency, byte A presented after the third following byte is accepted
        send_code(1'b0, 1'b0);
        expect_px(8'h5A, 1'b1, 1'b0);
        expect_px(8'h6B, 1'b0, 1'b0);
        expect_px(8'h7C, 1'b0, 1'b0);
        expect_px(8'h8D, 1'b0, 1'b0);
        send_raw(8'h5A);
        send_raw(8'h6B);
        send_raw(8'h7C);
        chk(got_n == 0, "R3", got_n, 0);
        send_raw(8'h8D);
        @(negedge clk);
        #1;
        chk(got_n == 1, "R3", got_n, 1);
        send_code(1'b1, 1'b0);
        hblank();

        // opening frame without preceding blanking: no frame start (R7)
        send_line(4, 1, 1'b0);
        send_line(6, 2, 1'b0);
        send_vblank_line(5); // R5
        send_vblank_line(2);

        // sweep of frames with varying line lengths, empty lines and blanking depth
        for (int f = 1; f <= 4; f++) begin
            for (int l = 0; l < 4; l++) begin
                int len;
                len = (f + 2 * l) % 6;
                if (l == 0 && len == 0) len = 1;
                send_line(len, f * 10 + l, l == 0);
            end
            for (int b = 0; b < 1 + f % 2; b++) send_vblank_line(3 + b);
        end
        send_line(3, 77, 1'b1);
        repeat (4) begin
            @(posedge clk);
            #1;
        end
        @(negedge clk);
        chk(got_n == exp_n, "R3", got_n, exp_n);
        chk(ev_got == ev_n, "R2", ev_got, ev_n);
        chk(!px_valid, "R9", px_valid, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule